// File: doc/BRIEF.md
# Dual-Slope Converter Phase Sequencer

This block is the digital controller of an integrating dual-slope analog-to-digital converter. It divides the oscillator clock by a fixed prescale to make a conversion count. On that count it cycles through four phases in a fixed order: integrator zeroing, offset auto-zero, fixed-length signal integration and reference deintegration. Each phase closes one analog switch group through a one-hot set of enables. A single comparator bit, which reports whether the integrator output is above zero, is the only analog feedback.

The signal phase always lasts the same number of counts. The deintegrate phase runs until the comparator reports a zero crossing, and the number of counts it took is the reading. That reading is delivered as three and a half BCD digits, together with a sign. A run that reaches the count limit without a crossing is reported as overrange. Every conversion lasts exactly the same number of counts. The zeroing and auto-zero phases take up whatever time deintegration leaves, and the previous result's overrange status sets the bounds of the zeroing phase. The integrator, comparator and reference lie outside the block.

Top module: `dslope_sequencer`

## Requirements
- R1: One count equals 4 clock cycles (parameter PRESCALE). Every phase lasts a whole number of counts, and the signal phase (sw_signal high) lasts exactly 1000 counts.
- R2: From one rise of sw_signal to the next, exactly 4000 counts (16000 clocks) pass, whatever the comparator does.
- R3: After the first conversion, the phases follow the order zeroing (sw_zero), auto-zero (sw_autozero), signal (sw_signal), deintegrate (sw_ref_dn or sw_ref_up), then zeroing again.
- R4: Deintegration ends at the first count where the comparator has crossed to the side opposite the one seen at the end of the signal phase. The reading is the number of deintegrate counts before that one. It appears as rd_thou (0 or 1), rd_hund, rd_tens and rd_ones, each a 4-bit BCD digit from 0 to 9.
- R5: The comparator value at the last signal count sets the sign: cmp_hi low gives rd_neg=1 and deintegration through sw_ref_up, and cmp_hi high gives rd_neg=0 and sw_ref_dn.
- R6: If no crossing is seen within 2000 deintegrate counts, deintegration stops after exactly 2000 counts with rd_over=1, all digits 0 and rd_neg still reporting the sign.
- R7: After a normal result, zeroing ends at the first count at or beyond count 11 where cmp_hi differs from its value at the end of deintegration. It ends at count 140 if no such difference appears.
- R8: After an overrange result, the zeroing bounds become 31 and 640 counts.
- R9: Auto-zero lasts for all the counts left in the 4000-count frame after the other three phases.
- R10: The digits, rd_neg and rd_over change only at the end of deintegration. rd_valid is high for exactly one clock at that point and low at all other times.
- R11: While rst_n is low, all switch enables and result outputs are 0. From the second clock after release, exactly one switch enable is high.
- R12: Reset starts a zeroing phase with the overrange bounds, placed so that the first sw_signal rise comes exactly 1000 counts (4000 clocks) after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_hi | input | 1 | Comparator: integrator output above zero |
| sw_zero | output | 1 | Integrator zeroing switches |
| sw_autozero | output | 1 | Offset auto-zero switches |
| sw_signal | output | 1 | Input signal integration switches |
| sw_ref_dn | output | 1 | Reference deintegrate after a positive input |
| sw_ref_up | output | 1 | Reference deintegrate after a negative input |
| rd_thou | output | 1 | Thousands digit (0 or 1) |
| rd_hund | output | 4 | Hundreds BCD digit |
| rd_tens | output | 4 | Tens BCD digit |
| rd_ones | output | 4 | Units BCD digit |
| rd_neg | output | 1 | Sign of the latched reading |
| rd_over | output | 1 | Latched reading is overrange |
| rd_valid | output | 1 | One-clock pulse when a result is latched |

## Verification
The comparator reaches the design through a register stage, and phase changes happen only on the clock edge that ends a count. A crossing that the model places after deintegrate count N therefore shows up as a phase change 4·(N+1) clocks after deintegration began. At the same edge the result registers load, so rd_valid and the new digits are visible on the first clock of the following zeroing phase. The bench counts, on falling edges, how many clocks each switch enable stays high, and compares those counts with 4 times the expected number of counts. It reads the result outputs on the first falling edge of zeroing and again at the end of auto-zero, and counts the falling edges on which rd_valid is high.

// File: rtl/dslope_sequencer.sv
module dslope_sequencer #(
  parameter int PRESCALE     = 4,
  parameter int TOTAL_COUNTS = 4000,
  parameter int SIG_COUNTS   = 1000,
  parameter int DEINT_MAX    = 2000,
  parameter int ZI_MIN       = 11,
  parameter int ZI_MAX       = 140,
  parameter int ZI_MIN_OVR   = 31,
  parameter int ZI_MAX_OVR   = 640
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_hi,
  output logic       sw_zero,
  output logic       sw_autozero,
  output logic       sw_signal,
  output logic       sw_ref_dn,
  output logic       sw_ref_up,
  output logic       rd_thou,
  output logic [3:0] rd_hund,
  output logic [3:0] rd_tens,
  output logic [3:0] rd_ones,
  output logic       rd_neg,
  output logic       rd_over,
  output logic       rd_valid
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int CW = $clog2(TOTAL_COUNTS);
  localparam int ND = 3;

  typedef enum logic [1:0] {PH_ZERO, PH_AZ, PH_SIG, PH_DE} phase_t;

  phase_t          ph;
  logic            run;
  logic [PW-1:0]   pre;
  logic [CW-1:0]   tot, cnt;
  logic            zref, pol_neg, ovr_q;
  logic [4*ND:0]   bcd, bcd_inc;
  logic            end_ph;

  wire             tick    = (pre == PW'(PRESCALE - 1));
  wire [CW-1:0]    cnt_n   = cnt + 1'b1;
  wire             crossed = (cmp_hi == pol_neg);
  wire             zi_zero = (cmp_hi != zref);
  wire [CW-1:0]    zmin    = ovr_q ? CW'(ZI_MIN_OVR) : CW'(ZI_MIN);
  wire [CW-1:0]    zmax    = ovr_q ? CW'(ZI_MAX_OVR) : CW'(ZI_MAX);

  always_comb begin
    case (ph)
      PH_ZERO: end_ph = (cnt_n >= zmin && zi_zero) || cnt_n == zmax;
      PH_AZ:   end_ph = (tot == CW'(TOTAL_COUNTS - 1));
      PH_SIG:  end_ph = (cnt_n == CW'(SIG_COUNTS));
      default: end_ph = crossed || cnt_n == CW'(DEINT_MAX);
    endcase
  end

  always_comb begin
    logic carry;
    carry = 1'b1;
    bcd_inc = bcd;
    for (int i = 0; i < ND; i++) begin
      if (carry) begin
        if (bcd[4*i +: 4] == 4'd9) bcd_inc[4*i +: 4] = 4'd0;
        else begin
          bcd_inc[4*i +: 4] = bcd[4*i +: 4] + 4'd1;
          carry = 1'b0;
        end
      end
    end
    bcd_inc[4*ND] = bcd[4*ND] | carry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre      <= '0;
      ph       <= PH_ZERO;
      run      <= 1'b0;
      tot      <= CW'(SIG_COUNTS + DEINT_MAX);
      cnt      <= '0;
      zref     <= 1'b0;
      pol_neg  <= 1'b0;
      ovr_q    <= 1'b1;
      bcd      <= '0;
      rd_valid <= 1'b0;
      rd_neg   <= 1'b0;
      rd_over  <= 1'b0;
      {rd_thou, rd_hund, rd_tens, rd_ones} <= '0;
    end else begin
      run      <= 1'b1;
      rd_valid <= 1'b0;
      pre      <= tick ? '0 : pre + 1'b1;
      if (tick) begin
        tot <= (ph == PH_AZ && end_ph) ? '0 : tot + 1'b1;
        cnt <= end_ph ? '0 : cnt_n;
        if (end_ph) ph <= phase_t'(ph + 2'd1);
        case (ph)
          PH_SIG: if (end_ph) begin
            pol_neg <= ~cmp_hi;
            bcd     <= '0;
          end
          PH_DE: if (end_ph) begin
            zref     <= cmp_hi;
            ovr_q    <= ~crossed;
            rd_valid <= 1'b1;
            rd_neg   <= pol_neg;
            rd_over  <= ~crossed;
            {rd_thou, rd_hund, rd_tens, rd_ones} <= crossed ? bcd : '0;
          end else begin
            bcd <= bcd_inc;
          end
          default: ;
        endcase
      end
    end
  end

  assign sw_zero     = run && ph == PH_ZERO;
  assign sw_autozero = run && ph == PH_AZ;
  assign sw_signal   = run && ph == PH_SIG;
  assign sw_ref_dn   = run && ph == PH_DE && !pol_neg;
  assign sw_ref_up   = run && ph == PH_DE && pol_neg;
endmodule

// File: rtl/dslope_sequencer_chk.sv
module dslope_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_zero,
  input logic       sw_autozero,
  input logic       sw_signal,
  input logic       sw_ref_dn,
  input logic       sw_ref_up,
  input logic       rd_thou,
  input logic [3:0] rd_hund,
  input logic [3:0] rd_tens,
  input logic [3:0] rd_ones,
  input logic       rd_neg,
  input logic       rd_over,
  input logic       rd_valid
);
  wire [4:0]  sw  = {sw_zero, sw_autozero, sw_signal, sw_ref_dn, sw_ref_up};
  wire        de  = sw_ref_dn | sw_ref_up;
  wire [14:0] res = {rd_thou, rd_hund, rd_tens, rd_ones, rd_neg, rd_over};

  assert_one_switch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $countones(sw) == 1);

  assert_sig_after_az_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_signal) |-> $past(sw_autozero));

  assert_de_after_sig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de) |-> $past(sw_signal));

  assert_zero_after_de_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sw_zero) && $past(rst_n, 2)) |-> $past(de));

  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_result_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(res));

  assert_valid_ends_de_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(de) && sw_zero));

  assert_sign_matches_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_neg == $past(sw_ref_up));

  assert_over_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_over |-> {rd_thou, rd_hund, rd_tens, rd_ones} == 13'd0);

  assert_bcd_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hund <= 4'd9 && rd_tens <= 4'd9 && rd_ones <= 4'd9);
endmodule

bind dslope_sequencer dslope_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .sw_zero(sw_zero), .sw_autozero(sw_autozero), .sw_signal(sw_signal),
  .sw_ref_dn(sw_ref_dn), .sw_ref_up(sw_ref_up),
  .rd_thou(rd_thou), .rd_hund(rd_hund), .rd_tens(rd_tens), .rd_ones(rd_ones),
  .rd_neg(rd_neg), .rd_over(rd_over), .rd_valid(rd_valid)
);

// File: tb/tb_dslope_sequencer.sv
module tb_dslope_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_hi = 1'b0;
  logic sw_zero, sw_autozero, sw_signal, sw_ref_dn, sw_ref_up;
  logic rd_thou, rd_neg, rd_over, rd_valid;
  logic [3:0] rd_hund, rd_tens, rd_ones;

  int checks = 0;
  int fails  = 0;
  int vcount = 0;

  bit in_pos = 1'b1;
  int de_n   = 0;
  int zi_k   = 20;

  dslope_sequencer dut (
    .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi),
    .sw_zero(sw_zero), .sw_autozero(sw_autozero), .sw_signal(sw_signal),
    .sw_ref_dn(sw_ref_dn), .sw_ref_up(sw_ref_up),
    .rd_thou(rd_thou), .rd_hund(rd_hund), .rd_tens(rd_tens), .rd_ones(rd_ones),
    .rd_neg(rd_neg), .rd_over(rd_over), .rd_valid(rd_valid)
  );

  always #10 clk = ~clk;

  // integrator and comparator model
  int  dec = 0, zc = 0;
  bit  held = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      cmp_hi <= 1'b0; dec = 0; zc = 0;
    end else if (sw_signal) begin
      cmp_hi <= in_pos; dec = 0; zc = 0;
    end else if (sw_ref_dn || sw_ref_up) begin
      dec++;
      cmp_hi <= (dec <= 4*de_n) ? in_pos : ~in_pos;
    end else if (sw_zero) begin
      if (zc == 0) held = cmp_hi;
      zc++;
      cmp_hi <= (zc <= 4*zi_k) ? held : ~held;
    end else begin
      dec = 0; zc = 0;
    end
    if (rst_n && rd_valid) vcount++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit ph_on(input int w);
    case (w)
      0: return sw_zero;
      1: return sw_autozero;
      2: return sw_signal;
      default: return sw_ref_dn | sw_ref_up;
    endcase
  endfunction

  task automatic meas(input int w, output int n);
    n = 0;
    while (ph_on(w)) begin n++; @(negedge clk); end
  endtask

  function automatic int res_val();
    return rd_thou*1000 + rd_hund*100 + rd_tens*10 + rd_ones;
  endfunction

  // called on the first falling edge showing sw_signal
  task automatic conv(input bit pos, input int n, input int k);
    int t_int, t_de, t_zi, t_az, v0, exp_de, exp_zi, lo, hi, exp_rd;
    bit ovr, used_up;
    in_pos = pos; de_n = n; zi_k = k;
    ovr    = (n >= 2000);
    exp_de = ovr ? 2000 : n + 1;
    lo     = ovr ? 31 : 11;
    hi     = ovr ? 640 : 140;
    exp_zi = (k + 1 < lo) ? lo : ((k + 1 > hi) ? hi : k + 1);
    exp_rd = ovr ? 0 : n;
    v0 = vcount;
    meas(2, t_int);
    chk(t_int == 4000, "R1 signal phase clocks", t_int, 4000);
    used_up = sw_ref_up;
    chk(used_up == !pos, "R5 reference side", used_up, !pos);
    meas(3, t_de);
    chk(t_de == 4*exp_de, ovr ? "R6 deintegrate clocks" : "R4 deintegrate clocks", t_de, 4*exp_de);
    chk(rd_valid && sw_zero, "R10 valid at deintegrate end", rd_valid, 1);
    chk(res_val() == exp_rd, ovr ? "R6 blank digits" : "R4 reading", res_val(), exp_rd);
    chk(rd_over == ovr, "R6 overrange flag", rd_over, ovr);
    chk(rd_neg == !pos, "R5 sign", rd_neg, !pos);
    meas(0, t_zi);
    chk(t_zi == 4*exp_zi, ovr ? "R8 zeroing clocks" : "R7 zeroing clocks", t_zi, 4*exp_zi);
    meas(1, t_az);
    chk(t_az == 4*(3000 - exp_de - exp_zi), "R9 auto-zero clocks", t_az, 4*(3000 - exp_de - exp_zi));
    chk(t_int + t_de + t_zi + t_az == 16000, "R2 frame clocks", t_int + t_de + t_zi + t_az, 16000);
    chk(sw_signal, "R3 signal follows auto-zero", sw_signal, 1);
    chk(res_val() == exp_rd && rd_over == ovr && rd_neg == !pos, "R10 result held", res_val(), exp_rd);
    chk(vcount - v0 == 1, "R10 one valid per frame", vcount - v0, 1);
  endtask

  task automatic t_reset;
    int n;
    repeat (3) @(negedge clk);
    chk({sw_zero, sw_autozero, sw_signal, sw_ref_dn, sw_ref_up} == 5'd0, "R11 switches off in reset",
        {sw_zero, sw_autozero, sw_signal, sw_ref_dn, sw_ref_up}, 0);
    chk({rd_thou, rd_hund, rd_tens, rd_ones, rd_neg, rd_over, rd_valid} == 0, "R11 results clear in reset",
        {rd_thou, rd_hund, rd_tens, rd_ones, rd_neg, rd_over, rd_valid}, 0);
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!sw_signal);
    chk(n == 4000, "R12 first signal phase after reset", n, 4000);
  endtask

  task automatic t_positive;   conv(1'b1, 1234, 50);  endtask
  task automatic t_negative;   conv(1'b0, 567, 5);    endtask
  task automatic t_zero_max;   conv(1'b1, 0, 200);    endtask
  task automatic t_full;       conv(1'b1, 1999, 20);  endtask
  task automatic t_over_min;   conv(1'b0, 3000, 10);  endtask
  task automatic t_over_max;   conv(1'b1, 5000, 700); endtask
  task automatic t_recover;    conv(1'b0, 808, 100);  endtask

  initial begin
    t_reset();
    t_positive();
    t_negative();
    t_zero_max();
    t_full();
    t_over_min();
    t_over_max();
    t_recover();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule